// File: doc/BRIEF.md
# Overlap-Sequenced Dual Gate Output Stage

This block turns one digital PWM command into two in-phase gate control signals for a single-ended power stage. The main output drives the primary switch. The auxiliary output drives an active clamp or a synchronous rectifier; if that switch needs an inverted signal, the inversion is done outside the block. On every turn-on the auxiliary output goes high first and the main output follows after an overlap delay of D clock cycles. On every turn-off the main output drops first and the auxiliary output follows D cycles later. This gives a guard band against cross-conduction.

D is taken from a configuration input at the start of each pulse, and the same D is used for both edges of that pulse. A kill input forces both outputs low at once, with no overlap sequencing. It is meant for line under/overvoltage faults. While the enable input is low, the outputs stay low and the delay counting is cleared. The block also reports when the command rises again before the trailing delay has ended. That situation means the chosen delay does not fit inside the command's off-time.

Top module: `ovl_gen`

## Requirements
- R1: The command is taken as high at clock edge k, with the block idle and D = `dly_cfg`. The auxiliary output is high from edge k, and the main output is high from edge k+D. When D = 0 both outputs rise at edge k.
- R2: The command is first sampled low at edge j, and the main output has already been high for at least one cycle. The main output is low from edge j. The auxiliary output is low from edge j+D.
- R3: The command may stay high for fewer than D+1 edges. The block still completes the full D-cycle lead. The main output is then high for exactly one cycle, and the full D-cycle trail follows.
- R4: The outputs are in phase. The main output is never high while the auxiliary output is low.
- R5: While `kill` is high, both outputs are low in the same cycle, with no delay applied. From the next edge the sequence state is cleared. After `kill` is released with the command still high, a fresh R1 sequence starts with the full lead.
- R6: While `en` is low, both outputs are held low and the delay count is cleared. When `en` returns high with the command high, the full D-cycle lead applies.
- R7: D is captured when a sequence starts. A change to `dly_cfg` during the sequence does not alter the lead or the trail of the pulse in progress.
- R8: If the command is sampled high during the trailing delay, the trail still runs to the end. The auxiliary output is then low for exactly one cycle before a new R1 sequence starts. `gap_short` is high for one cycle after each edge at which the command was sampled high during the trail.
- R9: During and directly after reset, `out_main`, `out_aux` and `gap_short` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; low holds both outputs low |
| kill | input | 1 | Fault kill; forces both outputs low at once |
| pwm_cmd | input | 1 | PWM command pulse |
| dly_cfg | input | DLY_W | Overlap delay D in clock cycles |
| out_main | output | 1 | Main switch gate control |
| out_aux | output | 1 | Clamp / rectifier gate control |
| gap_short | output | 1 | Command rose again during the trailing delay |

## Verification
The ordering assertions assume that `kill`, `en` and `pwm_cmd` are synchronous to `clk`. They also assume that `kill` is low before reset is released, so that the first sampled past value is defined. The lead and trail ordering checks apply only to edges that `kill` or a low `en` did not cause. The stimulus changes every input on the falling clock edge only. It asserts `kill` only after reset has completed. It also holds `dly_cfg` steady across each start edge, so that the captured D is known.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_ON    = 2'd2,
        ST_TRAIL = 2'd3
    } ovl_state_e;

    typedef struct packed {
        ovl_state_e state;
        logic       main;
        logic       aux;
        logic       gap;
    } ovl_seq_t;
endpackage

// File: rtl/ovl_dly_cnt.sv
module ovl_dly_cnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         run,
    input  logic [W-1:0] lim,
    output logic         hit
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (start)
            cnt_d = W'(1);
        else if (run)
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit = (cnt_q == lim);

    // R1 / R2: the counter never runs past the captured delay
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (cnt_q <= lim));
endmodule

// File: rtl/ovl_seq.sv
module ovl_seq
    import ovl_pkg::*;
#(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         kill,
    input  logic         cmd,
    input  logic [W-1:0] dly_cfg,
    input  logic         hit,
    output logic         cnt_start,
    output logic         cnt_run,
    output logic [W-1:0] dly_lim,
    output logic         main_o,
    output logic         aux_o,
    output logic         gap_o
);
    ovl_seq_t     seq_d, seq_q;
    logic [W-1:0] dly_d, dly_q;

    always_comb begin
        seq_d     = seq_q;
        seq_d.gap = 1'b0;
        dly_d     = dly_q;
        cnt_start = 1'b0;
        cnt_run   = 1'b0;
        if (!en || kill) begin
            seq_d.state = ST_IDLE;
            seq_d.main  = 1'b0;
            seq_d.aux   = 1'b0;
        end else begin
            unique case (seq_q.state)
                ST_IDLE: begin
                    if (cmd) begin
                        dly_d     = dly_cfg;
                        seq_d.aux = 1'b1;
                        if (dly_cfg == '0) begin
                            seq_d.main  = 1'b1;
                            seq_d.state = ST_ON;
                        end else begin
                            seq_d.state = ST_LEAD;
                            cnt_start   = 1'b1;
                        end
                    end
                end
                ST_LEAD: begin
                    if (hit) begin
                        seq_d.main  = 1'b1;
                        seq_d.state = ST_ON;
                    end else begin
                        cnt_run = 1'b1;
                    end
                end
                ST_ON: begin
                    if (!cmd) begin
                        seq_d.main = 1'b0;
                        if (dly_q == '0) begin
                            seq_d.aux   = 1'b0;
                            seq_d.state = ST_IDLE;
                        end else begin
                            seq_d.state = ST_TRAIL;
                            cnt_start   = 1'b1;
                        end
                    end
                end
                ST_TRAIL: begin
                    seq_d.gap = cmd;
                    if (hit) begin
                        seq_d.aux   = 1'b0;
                        seq_d.state = ST_IDLE;
                    end else begin
                        cnt_run = 1'b1;
                    end
                end
                default: seq_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, main: 1'b0, aux: 1'b0, gap: 1'b0};
            dly_q <= '0;
        end else begin
            seq_q <= seq_d;
            dly_q <= dly_d;
        end
    end

    assign dly_lim = dly_q;
    assign main_o  = seq_q.main;
    assign aux_o   = seq_q.aux;
    assign gap_o   = seq_q.gap;

    // R5: a kill seen at an edge leaves both registered outputs low
    a_r5_kill_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(kill) |-> (!seq_q.main && !seq_q.aux));

    // R6: a low enable leaves both registered outputs low
    a_r6_en_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (!seq_q.main && !seq_q.aux));

    // R1: with a nonzero delay the auxiliary output led the main rise
    a_r1_lead_order: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(seq_q.main) && dly_q != '0) |-> $past(seq_q.aux));

    // R2: an unforced auxiliary fall with nonzero delay follows a low main output
    a_r2_trail_order: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(seq_q.aux) && $past(en) && !$past(kill) && $past(dly_q) != '0)
        |-> !$past(seq_q.main));

    // R7: the captured delay stays fixed while a sequence is in progress
    a_r7_dly_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state != ST_IDLE && $past(seq_q.state) != ST_IDLE) |-> $stable(dly_q));
endmodule

// File: rtl/ovl_gen.sv
module ovl_gen #(
    parameter int DLY_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             kill,
    input  logic             pwm_cmd,
    input  logic [DLY_W-1:0] dly_cfg,
    output logic             out_main,
    output logic             out_aux,
    output logic             gap_short
);
    logic             cnt_start, cnt_run, hit;
    logic [DLY_W-1:0] dly_lim;
    logic             main_r, aux_r, gap_r;

    ovl_seq #(.W(DLY_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .kill      (kill),
        .cmd       (pwm_cmd),
        .dly_cfg   (dly_cfg),
        .hit       (hit),
        .cnt_start (cnt_start),
        .cnt_run   (cnt_run),
        .dly_lim   (dly_lim),
        .main_o    (main_r),
        .aux_o     (aux_r),
        .gap_o     (gap_r)
    );

    ovl_dly_cnt #(.W(DLY_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cnt_start),
        .run   (cnt_run),
        .lim   (dly_lim),
        .hit   (hit)
    );

    // Fault kill bypasses the registers so it acts within the same cycle
    assign out_main  = main_r & ~kill;
    assign out_aux   = aux_r & ~kill;
    assign gap_short = gap_r;

    // R4: outputs are in phase, the main never high alone
    a_r4_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
        out_main |-> out_aux);
endmodule

// File: tb/ovl_gen_tb.sv
module ovl_gen_tb;
    localparam int DLY_W = 6;
    localparam int NVEC  = 6;
    // {delay, command high edges, command low edges}
    localparam int VEC [NVEC][3] = '{
        '{0, 5, 6}, '{1, 5, 6}, '{3, 8, 10},
        '{5, 3, 12}, '{2, 10, 6}, '{7, 4, 14}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b1;
    logic             kill = 1'b0;
    logic             pwm_cmd = 1'b0;
    logic [DLY_W-1:0] dly_cfg = '0;
    logic             out_main, out_aux, gap_short;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ovl_gen #(.DLY_W(DLY_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .kill      (kill),
        .pwm_cmd   (pwm_cmd),
        .dly_cfg   (dly_cfg),
        .out_main  (out_main),
        .out_aux   (out_aux),
        .gap_short (gap_short)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic drain(input int n);
        pwm_cmd = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // One pulse: delay d at start, switched to d2 after the first edge
    task automatic run_pulse(input int d, input int d2, input int h, input int l);
        int fa = -1, fm = -1, lm = -1, la = -1, bad = 0, m;
        dly_cfg = DLY_W'(d);
        @(negedge clk);
        pwm_cmd = 1'b1;
        for (int t = 1; t <= h + l; t++) begin
            @(negedge clk);
            if (out_aux && fa < 0) fa = t;
            if (out_main && fm < 0) fm = t;
            if (out_main) lm = t;
            if (out_aux) la = t;
            if (out_main && !out_aux) bad++;
            if (t == 1) dly_cfg = DLY_W'(d2);
            if (t == h) pwm_cmd = 1'b0;
        end
        m = (h > d + 1) ? h : d + 1;
        chk($sformatf("R1 aux rise d=%0d", d), fa, 1);
        chk($sformatf("R1 main rise d=%0d", d), fm, 1 + d);
        chk($sformatf("%s main fall d=%0d h=%0d", (h < d + 1) ? "R3" : "R2", d, h), lm, m);
        chk($sformatf("R2 aux fall d=%0d", d), la, m + d);
        chk("R4 main without aux", bad, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        int lowcnt, gapcnt, fm2;
        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 outputs in reset", {out_main, out_aux, gap_short}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 outputs after reset", {out_main, out_aux, gap_short}, 0);

        // Table of pulses: R1, R2, R3, R4
        for (int i = 0; i < NVEC; i++)
            run_pulse(VEC[i][0], VEC[i][0], VEC[i][1], VEC[i][2]);

        // R7: delay changed mid-sequence is ignored
        run_pulse(3, 9, 6, 10);

        // R5: kill while both outputs high
        dly_cfg = 6'd4;
        @(negedge clk);
        pwm_cmd = 1'b1;
        repeat (8) @(negedge clk);
        chk("R5 main high before kill", out_main, 1);
        kill = 1'b1;
        #1;
        chk("R5 same-cycle kill", {out_main, out_aux}, 0);
        @(negedge clk);
        chk("R5 held low under kill", {out_main, out_aux}, 0);
        kill = 1'b0;
        @(negedge clk);
        chk("R5 restart aux/main", {out_aux, out_main}, 2);
        repeat (3) @(negedge clk);
        chk("R5 restart main still low", out_main, 0);
        @(negedge clk);
        chk("R5 restart main after full lead", out_main, 1);
        drain(12);

        // R6: enable low holds outputs low, lead restarts fully
        en = 1'b0;
        pwm_cmd = 1'b1;
        lowcnt = 0;
        for (int t = 0; t < 6; t++) begin
            @(negedge clk);
            if (out_main || out_aux) lowcnt++;
        end
        chk("R6 outputs low while disabled", lowcnt, 0);
        en = 1'b1;
        fm2 = -1;
        for (int t = 1; t <= 8; t++) begin
            @(negedge clk);
            if (t == 1) chk("R6 aux rises after enable", out_aux, 1);
            if (out_main && fm2 < 0) fm2 = t;
        end
        chk("R6 full lead after enable", fm2, 5);
        drain(12);
        chk("R9 flag idle", gap_short, 0);

        // R8: command rises again inside the trailing delay
        dly_cfg = 6'd4;
        @(negedge clk);
        pwm_cmd = 1'b1;
        lowcnt = 0;
        gapcnt = 0;
        fm2 = -1;
        for (int t = 1; t <= 24; t++) begin
            @(negedge clk);
            if (t >= 2 && t <= 15 && !out_aux) lowcnt++;
            if (gap_short) gapcnt++;
            if (t > 7 && out_main && fm2 < 0) fm2 = t;
            if (t == 6) pwm_cmd = 1'b0;
            if (t == 7) pwm_cmd = 1'b1;
        end
        chk("R8 aux low cycles between pulses", lowcnt, 1);
        chk("R8 gap flag cycles", gapcnt, 4);
        chk("R8 next main rise after full lead", fm2, 16);
        drain(16);
        chk("R8 idle after sequence", {out_main, out_aux}, 0);

        finish_run();
    end
endmodule